// File: doc/BRIEF.md
# Shared-Address DRAM Access Sequencer

This block connects a simple processor-side request port to a DRAM device whose address pins carry the row and the column address one after the other. A request carries a full address, a read/write flag and write data. The sequencer splits the address into a row half and a column half. It opens the row with an active-low row strobe and then performs the access with an active-low column strobe. It also drives write enable, output enable, chip select and its own write-data drive enable.

The most recently opened row stays open after an access. A later request to the same row goes straight to the column phase, so several accesses can share one row opening. A free-running timer raises a refresh request at a fixed interval. The refresh waits until the sequencer is idle. It then closes any open row and pulses the row strobe at a refresh row counter that advances after every refresh.

Read data is captured one clock after the column strobe falls. It is returned on a single-cycle valid pulse. The request port uses a valid/ready handshake. Ready is high only when the sequencer is idle and no refresh is waiting.

Top module: `dram_mux_seq`

## Requirements
- R1: During and directly after reset, dram_ras_no, dram_cas_no, dram_we_no, dram_oe_no and dram_cs_no are 1, dram_dq_oe_o and rd_valid_o are 0, and req_ready_o is 1.
- R2: A request whose row is not open first holds dram_ras_no high for 2 cycles. It then shows the row address req_addr_i[15:8] for 1 cycle with dram_ras_no high, and drives dram_ras_no low for 2 cycles. Next it places the column address req_addr_i[7:0] for 1 cycle with dram_cas_no high, then drives dram_cas_no low for 2 cycles. The row strobe is low for at least 2 cycles and high for at least 2 cycles between row openings.
- R3: In a write, dram_we_no is 0 and dram_dq_oe_o is 1 with dram_dq_o equal to the request's write data, from the column-address cycle through both column-strobe-low cycles. dram_we_no does not change while dram_cas_no is low.
- R4: In a read, dram_oe_no is 0 only during the 2 cycles with dram_cas_no low. dram_dq_i is sampled at the first clock edge after dram_cas_no falls, and rd_valid_o is 1 for exactly the following cycle with that value on rd_data_o.
- R5: After an access the row stays open, with dram_ras_no low while idle. A request whose row equals the open row skips the row phase: 1 column-address cycle, then 2 cycles of dram_cas_no low.
- R6: A refresh falls due every 64 clocks counted from reset release. When idle, it holds dram_ras_no high for 2 cycles and shows the refresh row for 1 cycle. It then drives dram_ras_no low for 2 cycles and high for 2 cycles, and leaves no row open. The refresh row starts at 0, advances by one after each refresh and wraps at 256.
- R7: req_ready_o is 1 only when idle with no refresh due. A request held while ready is 0 is accepted exactly once, at the first edge where ready is 1.
- R8: dram_cs_no is 0 whenever a strobe is low or an access or refresh is in progress. It is 1 only when idle with no open row.
- R9: dram_dq_oe_o and an active dram_oe_no are never present in the same cycle.
- R10: dram_cas_no is low only while dram_ras_no is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted at the next edge when high with valid |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | 16 | Full word address, row in the upper half |
| req_wdata_i | input | 16 | Write data |
| rd_valid_o | output | 1 | One-cycle read-data valid pulse |
| rd_data_o | output | 16 | Read data |
| dram_addr_o | output | 8 | Shared row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Device output enable, active low |
| dram_cs_no | output | 1 | Chip select, active low |
| dram_dq_o | output | 16 | Write data toward the device |
| dram_dq_oe_o | output | 1 | Controller drives the data bus |
| dram_dq_i | input | 16 | Read data from the device |

## Verification
The in-line properties check on every cycle the pin-level rules that hold in any sequence. Both strobes stay low for at least two cycles and the row strobe stays high for at least two cycles. The column strobe falls only inside an open row, and write enable holds steady while the column strobe is low. Chip select covers every strobe, the two data-bus drivers never overlap, a waiting refresh is held until it is taken, and the read-valid pulse lasts one cycle. Only the bench scenarios can show the rest. That covers the address split and the exact phase order, the row-hit shortcut, and where refreshes fall against held requests. It also covers the advance and wrap of the refresh row and whether the data written through the pins comes back on reads.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_RPRE,
    ST_RROW,
    ST_RRAS,
    ST_RREC
  } seq_state_e;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int PERIOD = 64,
  parameter int ROW_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic             done_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
      row_o  <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)       pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
      if (done_i) row_o <= row_o + 1'b1;
    end
  end

  // R6
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !ack_i) |=> pend_o);
endmodule

// File: rtl/dram_row_tracker.sv
module dram_row_tracker #(
  parameter int ROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] cmp_row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             hit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      row_o  <= '0;
    end else if (open_i) begin
      open_o <= 1'b1;
      row_o  <= row_i;
    end else if (close_i) begin
      open_o <= 1'b0;
    end
  end

  assign hit_o = open_o && (row_o == cmp_row_i);
endmodule

// File: rtl/dram_rd_capture.sv
module dram_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) data_o <= dq_i;
    end
  end

  // R4
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/dram_mux_seq.sv
module dram_mux_seq
  import dram_seq_pkg::*;
#(
  parameter  int ADDR_W     = 16,
  parameter  int DATA_W     = 16,
  parameter  int REF_PERIOD = 64,
  parameter  int T_STB      = 2,
  parameter  int T_PRE      = 2,
  localparam int ROW_W      = ADDR_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ROW_W-1:0]  dram_addr_o,
  output logic              dram_ras_no,
  output logic              dram_cas_no,
  output logic              dram_we_no,
  output logic              dram_oe_no,
  output logic              dram_cs_no,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [DATA_W-1:0] dram_dq_i
);
  localparam int MAXL = (T_STB > T_PRE) ? T_STB : T_PRE;
  localparam int CW   = $clog2(MAXL + 1);

  seq_state_e        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d, last;
  logic              done, accept;
  logic              we_q;
  logic [ROW_W-1:0]  row_q, col_q;
  logic [DATA_W-1:0] wdata_q;
  logic              ref_pend, ref_ack, ref_done;
  logic [ROW_W-1:0]  ref_row;
  logic              row_open, row_hit, row_set, row_close;
  logic [ROW_W-1:0]  open_row;
  logic              cap;

  always_comb begin
    case (state_q)
      ST_PRE, ST_RPRE, ST_RREC: last = CW'(T_PRE - 1);
      ST_RAS, ST_CAS, ST_RRAS:  last = CW'(T_STB - 1);
      default:                  last = '0;
    endcase
  end

  assign done        = (cnt_q == last);
  assign req_ready_o = (state_q == ST_IDLE) && !ref_pend;
  assign accept      = req_ready_o && req_valid_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (ref_pend)    state_d = ST_RPRE;
        else if (accept) state_d = row_hit ? ST_COL : ST_PRE;
      end
      ST_PRE:  if (done) state_d = ST_ROW;
      ST_ROW:  if (done) state_d = ST_RAS;
      ST_RAS:  if (done) state_d = ST_COL;
      ST_COL:  if (done) state_d = ST_CAS;
      ST_CAS:  if (done) state_d = ST_IDLE;
      ST_RPRE: if (done) state_d = ST_RROW;
      ST_RROW: if (done) state_d = ST_RRAS;
      ST_RRAS: if (done) state_d = ST_RREC;
      ST_RREC: if (done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_d = (state_d != state_q || state_q == ST_IDLE) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (accept) begin
        we_q    <= req_we_i;
        row_q   <= req_addr_i[ADDR_W-1 -: ROW_W];
        col_q   <= req_addr_i[ROW_W-1:0];
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign ref_ack   = (state_q == ST_IDLE) && ref_pend;
  assign ref_done  = (state_q == ST_RREC) && done;
  assign row_set   = (state_q == ST_RAS) && done;
  assign row_close = ref_ack || (accept && !row_hit);
  assign cap       = (state_q == ST_CAS) && (cnt_q == '0) && !we_q;

  dram_refresh_timer #(.PERIOD(REF_PERIOD), .ROW_W(ROW_W)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ref_ack),
    .done_i (ref_done),
    .pend_o (ref_pend),
    .row_o  (ref_row)
  );

  dram_row_tracker #(.ROW_W(ROW_W)) u_row (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .open_i    (row_set),
    .row_i     (row_q),
    .close_i   (row_close),
    .cmp_row_i (req_addr_i[ADDR_W-1 -: ROW_W]),
    .open_o    (row_open),
    .row_o     (open_row),
    .hit_o     (row_hit)
  );

  dram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .dq_i    (dram_dq_i),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );

  logic col_phase;
  assign col_phase = (state_q == ST_COL) || (state_q == ST_CAS);

  always_comb begin
    case (state_q)
      ST_COL, ST_CAS:   dram_addr_o = col_q;
      ST_RROW, ST_RRAS: dram_addr_o = ref_row;
      ST_IDLE:          dram_addr_o = open_row;
      default:          dram_addr_o = row_q;
    endcase
  end

  assign dram_ras_no  = !((state_q == ST_RAS) || col_phase || (state_q == ST_RRAS) ||
                          ((state_q == ST_IDLE) && row_open));
  assign dram_cas_no  = (state_q != ST_CAS);
  assign dram_we_no   = !(we_q && col_phase);
  assign dram_oe_no   = !(!we_q && (state_q == ST_CAS));
  assign dram_dq_oe_o = we_q && col_phase;
  assign dram_dq_o    = wdata_q;
  assign dram_cs_no   = (state_q == ST_IDLE) && !row_open;

  // R2
  ras_low_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |=> !dram_ras_no);
  // R2
  ras_high_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_ras_no) |=> dram_ras_no);
  // R2
  cas_low_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) |=> !dram_cas_no);
  // R10
  cas_in_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no |-> !dram_ras_no);
  // R3
  we_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no |-> $stable(dram_we_no));
  // R8
  cs_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dram_ras_no || !dram_cas_no) |-> !dram_cs_no);
  // R9
  bus_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dram_dq_oe_o && !dram_oe_no));
  // R7
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> dram_cas_no);
endmodule

// File: tb/dram_mux_seq_bench.sv
module dram_mux_seq_bench;
  localparam int P = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_we_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        rd_valid_o;
  logic [15:0] rd_data_o;
  logic [7:0]  dram_addr_o;
  logic        dram_ras_no, dram_cas_no, dram_we_no, dram_oe_no, dram_cs_no;
  logic [15:0] dram_dq_o;
  logic        dram_dq_oe_o;
  logic [15:0] dram_dq_i = '0;

  always #5 clk_i = ~clk_i;

  dram_mux_seq u_dram_mux_seq (.*);

  int n_vec = 0;
  int n_bad = 0;
  int n_rd_req = 0;
  int n_rd_seen = 0;
  bit done_flag = 0;

  // behavioural DRAM device
  logic [15:0] dmem [int];
  logic [7:0]  dev_row;
  always @(negedge dram_ras_no) if (!dram_cs_no) dev_row = dram_addr_o;
  always @(negedge dram_cas_no) begin
    if (!dram_cs_no) begin
      if (!dram_we_no) dmem[{dev_row, dram_addr_o}] = dram_dq_o;
      else dram_dq_i = dmem.exists({dev_row, dram_addr_o}) ? dmem[{dev_row, dram_addr_o}] : 16'h0;
    end
  end

  // expected per-cycle pin vector
  typedef struct packed {
    logic       ras, cas, we, oe, cs, rdy, dqoe, rdv, chk;
    logic [7:0] addr;
    logic [15:0] rdata;
    logic [15:0] wdata;
    logic [3:0] kind;   // 2 miss, 5 hit, 6 refresh, 7 idle
  } vec_t;

  vec_t        q[$];
  vec_t        cur;
  bit          cur_idle;
  bit          m_open, m_pend;
  logic [7:0]  m_row, m_rrow;
  int          m_n;
  logic [15:0] emem [int];

  function automatic vec_t mk(logic ras, logic cas, logic we, logic oe, logic rdy,
                              logic dqoe, logic rdv, logic chk, logic [7:0] a,
                              logic [15:0] rd, logic [15:0] wd, logic [3:0] k, logic cs);
    vec_t v;
    v.ras = ras; v.cas = cas; v.we = we; v.oe = oe; v.cs = cs; v.rdy = rdy;
    v.dqoe = dqoe; v.rdv = rdv; v.chk = chk; v.addr = a; v.rdata = rd;
    v.wdata = wd; v.kind = k;
    return v;
  endfunction

  function automatic vec_t idle_vec(bit open, bit pend);
    return mk(!open, 1, 1, 1, !pend, 0, 0, 0, 8'h0, 16'h0, 16'h0, 4'd7, !open);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete();
      m_open = 0; m_pend = 0; m_row = 0; m_rrow = 0; m_n = 0;
      cur_idle = 1;
      cur = idle_vec(0, 0);
    end else begin
      bit hs;
      m_n++;
      hs = cur_idle && cur.rdy && req_valid_i;
      if (q.size() > 0) begin
        cur = q.pop_front(); cur_idle = 0;
      end else if (cur_idle && m_pend) begin
        for (int i = 0; i < 2; i++) q.push_back(mk(1,1,1,1,0,0,0,0,8'h0,0,0,4'd6,0));
        q.push_back(mk(1,1,1,1,0,0,0,1,m_rrow,0,0,4'd6,0));
        for (int i = 0; i < 2; i++) q.push_back(mk(0,1,1,1,0,0,0,1,m_rrow,0,0,4'd6,0));
        for (int i = 0; i < 2; i++) q.push_back(mk(1,1,1,1,0,0,0,0,8'h0,0,0,4'd6,0));
        m_rrow = m_rrow + 8'd1;
        m_pend = 0; m_open = 0;
        cur = q.pop_front(); cur_idle = 0;
      end else if (hs) begin
        logic [7:0]  r, c;
        logic [15:0] rd, wd;
        logic        w;
        logic [3:0]  k;
        bit          hit;
        r = req_addr_i[15:8]; c = req_addr_i[7:0]; w = req_we_i; wd = req_wdata_i;
        rd = emem.exists(int'(req_addr_i)) ? emem[int'(req_addr_i)] : 16'h0;
        if (w) emem[int'(req_addr_i)] = wd;
        hit = m_open && (m_row == r);
        k = hit ? 4'd5 : 4'd2;
        if (!hit) begin
          for (int i = 0; i < 2; i++) q.push_back(mk(1,1,1,1,0,0,0,0,8'h0,0,0,k,0));
          q.push_back(mk(1,1,1,1,0,0,0,1,r,0,0,k,0));
          for (int i = 0; i < 2; i++) q.push_back(mk(0,1,1,1,0,0,0,1,r,0,0,k,0));
        end
        q.push_back(mk(0,1,!w,1,0,w,0,1,c,0,wd,k,0));
        q.push_back(mk(0,0,!w,w,0,w,0,1,c,0,wd,k,0));
        q.push_back(mk(0,0,!w,w,0,w,!w,1,c,rd,wd,k,0));
        m_open = 1; m_row = r;
        cur = q.pop_front(); cur_idle = 0;
      end else begin
        cur_idle = 1;
      end
      if (m_n % P == 0) m_pend = 1;
      if (cur_idle) cur = idle_vec(m_open, m_pend);
    end
  end

  function automatic string ctx(logic [3:0] k);
    case (k)
      4'd2:    return "R2";
      4'd5:    return "R5";
      4'd6:    return "R6";
      default: return "R5";
    endcase
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni && !done_flag) begin
      bit bad;
      bad = 0;
      n_vec++;
      if (dram_ras_no !== cur.ras) begin bad = 1;
        $display("FAIL %s ras: act %b exp %b @%0t", ctx(cur.kind), dram_ras_no, cur.ras, $time); end
      if (dram_cas_no !== cur.cas) begin bad = 1;
        $display("FAIL R10 cas: act %b exp %b @%0t", dram_cas_no, cur.cas, $time); end
      if (cur.chk && dram_addr_o !== cur.addr) begin bad = 1;
        $display("FAIL %s addr: act %h exp %h @%0t", ctx(cur.kind), dram_addr_o, cur.addr, $time); end
      if (dram_we_no !== cur.we) begin bad = 1;
        $display("FAIL R3 we_n: act %b exp %b @%0t", dram_we_no, cur.we, $time); end
      if (dram_oe_no !== cur.oe) begin bad = 1;
        $display("FAIL R9 oe_n: act %b exp %b @%0t", dram_oe_no, cur.oe, $time); end
      if (dram_dq_oe_o !== cur.dqoe) begin bad = 1;
        $display("FAIL R9 dq_oe: act %b exp %b @%0t", dram_dq_oe_o, cur.dqoe, $time); end
      if (cur.dqoe && dram_dq_o !== cur.wdata) begin bad = 1;
        $display("FAIL R3 dq_o: act %h exp %h @%0t", dram_dq_o, cur.wdata, $time); end
      if (dram_cs_no !== cur.cs) begin bad = 1;
        $display("FAIL R8 cs_n: act %b exp %b @%0t", dram_cs_no, cur.cs, $time); end
      if (req_ready_o !== cur.rdy) begin bad = 1;
        $display("FAIL R7 ready: act %b exp %b @%0t", req_ready_o, cur.rdy, $time); end
      if (rd_valid_o !== cur.rdv) begin bad = 1;
        $display("FAIL R4 rd_valid: act %b exp %b @%0t", rd_valid_o, cur.rdv, $time); end
      if (cur.rdv && rd_data_o !== cur.rdata) begin bad = 1;
        $display("FAIL R4 rd_data: act %h exp %h @%0t", rd_data_o, cur.rdata, $time); end
      if (rd_valid_o === 1'b1) n_rd_seen++;
      if (bad) n_bad++;
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act %0h exp %0h", what, act, exp);
    end
  endtask

  task automatic issue(bit w, logic [15:0] a, logic [15:0] d);
    @(negedge clk_i);
    req_valid_i = 1; req_we_i = w; req_addr_i = a; req_wdata_i = d;
    while (req_ready_o !== 1'b1) @(negedge clk_i);
    if (!w) n_rd_req++;
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      n_bad++;
      $display("FAIL watchdog: act %0d cycles exp completion", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(dram_ras_no === 1'b1, "R1 ras_n in reset", int'(dram_ras_no), 1);
    chk(dram_cas_no === 1'b1, "R1 cas_n in reset", int'(dram_cas_no), 1);
    chk(dram_we_no === 1'b1 && dram_oe_no === 1'b1, "R1 we_n/oe_n in reset",
        int'({dram_we_no, dram_oe_no}), 3);
    chk(dram_cs_no === 1'b1, "R1 cs_n in reset", int'(dram_cs_no), 1);
    chk(dram_dq_oe_o === 1'b0 && rd_valid_o === 1'b0, "R1 dq_oe/rd_valid in reset",
        int'({dram_dq_oe_o, rd_valid_o}), 0);
    chk(req_ready_o === 1'b1, "R1 ready in reset", int'(req_ready_o), 1);
    @(posedge clk_i); #2 rst_ni = 1;

    issue(1, 16'h1234, 16'hBEEF);   // R2 closed-row write
    issue(0, 16'h1234, 16'h0);      // R5 hit read
    issue(1, 16'h1256, 16'h0A0A);   // R5 hit write
    issue(0, 16'h1256, 16'h0);
    issue(0, 16'h4400, 16'h0);      // R2 miss read, unwritten
    issue(1, 16'h44FF, 16'h1111);
    issue(0, 16'h1234, 16'h0);      // R2 miss back to first row
    for (int i = 0; i < 6; i++) issue(1, {8'h77, 8'(i * 3)}, 16'(16'hC000 + i));
    for (int i = 0; i < 6; i++) issue(0, {8'h77, 8'(i * 3)}, 16'h0);
    repeat (200) @(negedge clk_i);  // R6 refreshes while idle
    // R7 continuous held requests interleaved with refresh
    for (int i = 0; i < 40; i++) issue(i[0], {8'(i % 5), 8'(i)}, 16'(i * 257));
    repeat (16500) @(negedge clk_i); // R6 refresh row wrap
    issue(0, 16'h1256, 16'h0);
    issue(0, 16'h44FF, 16'h0);
    issue(1, 16'hFFFF, 16'h5A5A);
    issue(0, 16'hFFFF, 16'h0);
    repeat (20) @(negedge clk_i);
    // R4 one valid pulse per read
    chk(n_rd_seen == n_rd_req, "R4 read pulse count", n_rd_seen, n_rd_req);
    chk(dmem.exists(16'hFFFF) && dmem[16'hFFFF] == 16'h5A5A, "R3 device holds written word",
        dmem.exists(16'hFFFF) ? int'(dmem[16'hFFFF]) : -1, 16'h5A5A);
    finish_run();
  end
endmodule